// File: doc/BRIEF.md
# Timer Bank Register Front-End

This block is the bus-facing side of a bank of timer channels. It decodes 32-bit word accesses inside a 4 KiB window. It owns the registers that all channels share: a packed control word with a 4-bit field per channel, an event status word, a lock flag, and a bulk-clear port. For the per-channel registers it only routes: it raises a one-cycle write strobe toward the addressed channel and multiplexes that channel's readback onto the bus. The channels count on their own; this block only hands them their control fields.

The control fields reach the channels through a small sequencer per channel. The sequencer keeps a channel stopped while its configuration changes. When a single control write both switches a channel off and alters its other fields, the channel stops first and takes the new settings one cycle later. When a write switches a channel on and alters its settings, the settings land first and the channel starts one cycle later. Bulk clearing of control fields is refused until an unlock code has been written.

Top module: `tmrbank_front`

## Requirements
- R1: Slots below LOW_CH (16 bytes each from offset 0x00) map to channels 0..LOW_CH-1. Slot LOW_CH (0x30..0x3C) holds the shared registers. Slots LOW_CH+1..N_CH map to channels LOW_CH..N_CH-1. Within a slot, address bits [3:2] select word 0..3 (count, reload, first match, second match). That index is presented on `ch_rd_sel`, and a read returns the addressed channel's `ch_rd_data` word.
- R2: A write to a channel word raises exactly one bit of `ch_wr_stb`, the one for that channel, for one cycle after the request. `ch_wr_sel` carries the word index and `ch_wr_data` the data in that same cycle.
- R3: The control word at 0x30 is written and read back whole. Channel n owns bits 4n..4n+3, and within the field bit 0 is run enable, bit 1 is external clock select, bit 2 is overflow interrupt enable and bit 3 is pulse enable.
- R4: Channels with index below PULSE_FIRST ignore a pulse enable bit: it reads back as 0 and their `ch_pulse` stays 0. Channels at or above PULSE_FIRST accept it.
- R5: A control write that switches a channel on while changing its other fields updates `ch_extclk`/`ch_ovf_ie`/`ch_pulse` two cycles after the request and raises `ch_en` one cycle after that. With no field change, `ch_en` rises two cycles after the request.
- R6: A control write that switches a channel off while changing its other fields drops `ch_en` two cycles after the request, and the other fields change one cycle after that.
- R7: At 0x38, write data bits [8:1] equal to 0xAE set the lock flag open and 0xEA close it. Any other code leaves the flag unchanged. A read of 0x38 returns the flag in bit 0 (1 = open).
- R8: A write to 0x3C while open clears every control bit set in the data. While closed it has no effect.
- R9: A `ch_evt` pulse sets the matching bit of the status word at 0x34. A write to 0x34 ANDs the data into it, and an event arriving in the same cycle as that write still sets its bit.
- R10: Reads of 0x3C, of unaligned addresses and of offsets past the last channel slot return 0. Writes to offsets past the last channel slot change nothing.
- R11: A synchronous reset clears the control word, the status word and the lock flag, and drives all channel control outputs and strobes low.
- R12: Read data and `bus_rvalid` appear one cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| ch_wr_stb | output | N_CH | Per-channel write strobe |
| ch_wr_sel | output | 2 | Word index of the channel write |
| ch_wr_data | output | 32 | Data of the channel write |
| ch_rd_sel | output | 2 | Word index the channels must present |
| ch_rd_data | input | 32*N_CH | Readback word from each channel |
| ch_evt | input | N_CH | Per-channel event pulses |
| ch_en | output | N_CH | Run enable per channel |
| ch_extclk | output | N_CH | External clock select per channel |
| ch_ovf_ie | output | N_CH | Overflow interrupt enable per channel |
| ch_pulse | output | N_CH | Pulse enable per channel |

## Verification
The bench builds the block with its defaults: eight channels, three below the shared slot, pulse support from index 4, and a 12-bit address. With these values both channel regions on either side of the shared slot are reachable, as is the last valid slot at 0x80 and the first empty one at 0x90. Channels on both sides of the pulse boundary can be compared, and the full 32-bit control word is exercised by single writes, so the order of enable and disable against field changes is visible on individual outputs.

// File: rtl/tmrbank_pkg.sv
`timescale 1ns/1ps
package tmrbank_pkg;
  localparam int WORD_W  = 32;
  localparam int FIELD_W = 4;
  localparam int BIT_EN  = 0;
  localparam int BIT_CFG = 1;   // three config bits follow the enable
  localparam int CFG_W   = 3;

  localparam logic [7:0] CODE_OPEN = 8'hAE;
  localparam logic [7:0] CODE_SHUT = 8'hEA;

  typedef enum logic [2:0] {
    HIT_NONE,
    HIT_CHAN,
    HIT_CTRL,
    HIT_STAT,
    HIT_LOCK,
    HIT_CLR
  } hit_e;
endpackage

// File: rtl/tmrbank_decode.sv
`timescale 1ns/1ps
module tmrbank_decode import tmrbank_pkg::*; #(
  parameter int AW     = 12,
  parameter int N_CH   = 8,
  parameter int LOW_CH = 3
) (
  input  logic [AW-1:0]                      addr,
  output hit_e                               hit,
  output logic [((N_CH>1)?$clog2(N_CH):1)-1:0] ch,
  output logic [1:0]                         sel
);
  localparam int SW  = AW - 4;
  localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [SW-1:0] slot;
  logic          aligned;

  assign slot    = addr[AW-1:4];
  assign sel     = addr[3:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    hit = HIT_NONE;
    ch  = '0;
    if (aligned) begin
      if (slot < SW'(LOW_CH)) begin
        hit = HIT_CHAN;
        ch  = CHW'(slot);
      end else if (slot == SW'(LOW_CH)) begin
        unique case (sel)
          2'd0: hit = HIT_CTRL;
          2'd1: hit = HIT_STAT;
          2'd2: hit = HIT_LOCK;
          default: hit = HIT_CLR;
        endcase
      end else if (slot <= SW'(N_CH)) begin
        hit = HIT_CHAN;
        ch  = CHW'(slot - SW'(1));
      end
    end
  end
endmodule

// File: rtl/tmrbank_ctrl.sv
`timescale 1ns/1ps
module tmrbank_ctrl import tmrbank_pkg::*; #(
  parameter int N_CH        = 8,
  parameter int PULSE_FIRST = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_ctrl,
  input  logic                    wr_lock,
  input  logic                    wr_clr,
  input  logic [WORD_W-1:0]       wdata,
  output logic [FIELD_W*N_CH-1:0] ctrl_q,
  output logic                    open_q
);
  localparam int CW = FIELD_W * N_CH;

  logic [CW-1:0] keep;
  logic [7:0]    code;

  // pulse bit survives only on channels that support it
  for (genvar g = 0; g < N_CH; g++) begin : g_keep
    if (g >= PULSE_FIRST) begin : g_full
      assign keep[FIELD_W*g +: FIELD_W] = {FIELD_W{1'b1}};
    end else begin : g_nopulse
      assign keep[FIELD_W*g +: FIELD_W] = {1'b0, {(FIELD_W-1){1'b1}}};
    end
  end

  assign code = wdata[8:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      open_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= wdata[CW-1:0] & keep;
      end else if (wr_clr && open_q) begin
        ctrl_q <= ctrl_q & ~wdata[CW-1:0];
      end
      if (wr_lock) begin
        if (code == CODE_OPEN) begin
          open_q <= 1'b1;
        end else if (code == CODE_SHUT) begin
          open_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tmrbank_seq.sv
`timescale 1ns/1ps
module tmrbank_seq import tmrbank_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             want_en,
  input  logic [CFG_W-1:0] want_cfg,
  output logic             en_q,
  output logic [CFG_W-1:0] cfg_q
);
  // stop first, reconfigure while stopped, start only on settled config
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      cfg_q <= '0;
    end else if (en_q && !want_en) begin
      en_q <= 1'b0;
    end else if (!en_q) begin
      cfg_q <= want_cfg;
      en_q  <= want_en && (cfg_q == want_cfg);
    end else begin
      cfg_q <= want_cfg;
    end
  end
endmodule

// File: rtl/tmrbank_front.sv
`timescale 1ns/1ps
module tmrbank_front import tmrbank_pkg::*; #(
  parameter int AW          = 12,
  parameter int N_CH        = 8,
  parameter int LOW_CH      = 3,
  parameter int PULSE_FIRST = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_req,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [WORD_W-1:0]      bus_wdata,
  output logic [WORD_W-1:0]      bus_rdata,
  output logic                   bus_rvalid,
  output logic [N_CH-1:0]        ch_wr_stb,
  output logic [1:0]             ch_wr_sel,
  output logic [WORD_W-1:0]      ch_wr_data,
  output logic [1:0]             ch_rd_sel,
  input  logic [WORD_W*N_CH-1:0] ch_rd_data,
  input  logic [N_CH-1:0]        ch_evt,
  output logic [N_CH-1:0]        ch_en,
  output logic [N_CH-1:0]        ch_extclk,
  output logic [N_CH-1:0]        ch_ovf_ie,
  output logic [N_CH-1:0]        ch_pulse
);
  localparam int CW  = FIELD_W * N_CH;
  localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1;

  hit_e            hit;
  logic [CHW-1:0]  dch;
  logic [1:0]      dsel;
  logic            rd, wr;
  logic [CW-1:0]   ctrl_q;
  logic            open_q;
  logic [N_CH-1:0] stat_q;
  logic [WORD_W-1:0] rd_val;
  logic [CFG_W-1:0]  cfg_w [N_CH];

  assign rd = bus_req & ~bus_we;
  assign wr = bus_req & bus_we;

  tmrbank_decode #(.AW(AW), .N_CH(N_CH), .LOW_CH(LOW_CH)) u_dec (
    .addr (bus_addr),
    .hit  (hit),
    .ch   (dch),
    .sel  (dsel)
  );

  assign ch_rd_sel = dsel;

  tmrbank_ctrl #(.N_CH(N_CH), .PULSE_FIRST(PULSE_FIRST)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr && (hit == HIT_CTRL)),
    .wr_lock (wr && (hit == HIT_LOCK)),
    .wr_clr  (wr && (hit == HIT_CLR)),
    .wdata   (bus_wdata),
    .ctrl_q  (ctrl_q),
    .open_q  (open_q)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    tmrbank_seq u_seq (
      .clk      (clk),
      .rst      (rst),
      .want_en  (ctrl_q[FIELD_W*g + BIT_EN]),
      .want_cfg (ctrl_q[FIELD_W*g + BIT_CFG +: CFG_W]),
      .en_q     (ch_en[g]),
      .cfg_q    (cfg_w[g])
    );
    assign ch_extclk[g] = cfg_w[g][0];
    assign ch_ovf_ie[g] = cfg_w[g][1];
    assign ch_pulse[g]  = cfg_w[g][2];
  end

  // event status: write ANDs, events set and win over a same-cycle write
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else if (wr && (hit == HIT_STAT)) begin
      stat_q <= (stat_q & bus_wdata[N_CH-1:0]) | ch_evt;
    end else begin
      stat_q <= stat_q | ch_evt;
    end
  end

  always_comb begin
    unique case (hit)
      HIT_CHAN: rd_val = ch_rd_data[WORD_W*dch +: WORD_W];
      HIT_CTRL: rd_val = WORD_W'(ctrl_q);
      HIT_STAT: rd_val = WORD_W'(stat_q);
      HIT_LOCK: rd_val = WORD_W'(open_q);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      ch_wr_stb  <= '0;
      ch_wr_sel  <= '0;
      ch_wr_data <= '0;
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rd_val : '0;
      ch_wr_stb  <= (wr && (hit == HIT_CHAN)) ?
                    ({{(N_CH-1){1'b0}}, 1'b1} << dch) : '0;
      if (wr && (hit == HIT_CHAN)) begin
        ch_wr_sel  <= dsel;
        ch_wr_data <= bus_wdata;
      end
    end
  end
endmodule

// File: rtl/tmrbank_front_chk.sv
`timescale 1ns/1ps
module tmrbank_front_chk #(
  parameter int N_CH        = 8,
  parameter int PULSE_FIRST = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_req,
  input logic            bus_we,
  input logic            bus_rvalid,
  input logic [N_CH-1:0] ch_wr_stb,
  input logic [N_CH-1:0] ch_evt,
  input logic [N_CH-1:0] stat_q,
  input logic [N_CH-1:0] ch_en,
  input logic [N_CH-1:0] ch_extclk,
  input logic [N_CH-1:0] ch_ovf_ie,
  input logic [N_CH-1:0] ch_pulse
);
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_wr_stb));

  a_r12_read_valid: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);

  a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && !bus_we) |=> !bus_rvalid);

  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> (ch_en == '0 && stat_q == '0 && ch_wr_stb == '0));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    a_r5_start_on_settled_cfg: assert property (@(posedge clk) disable iff (rst)
      $rose(ch_en[i]) |-> $stable({ch_pulse[i], ch_ovf_ie[i], ch_extclk[i]}));

    a_r6_stop_before_cfg: assert property (@(posedge clk) disable iff (rst)
      $fell(ch_en[i]) |-> $stable({ch_pulse[i], ch_ovf_ie[i], ch_extclk[i]}));

    a_r9_event_sets: assert property (@(posedge clk) disable iff (rst)
      ch_evt[i] |=> stat_q[i]);

    if (i < PULSE_FIRST) begin : g_nopulse
      a_r4_no_pulse: assert property (@(posedge clk) disable iff (rst)
        !ch_pulse[i]);
    end
  end
endmodule

bind tmrbank_front tmrbank_front_chk #(.N_CH(N_CH), .PULSE_FIRST(PULSE_FIRST)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_rvalid (bus_rvalid),
  .ch_wr_stb  (ch_wr_stb),
  .ch_evt     (ch_evt),
  .stat_q     (stat_q),
  .ch_en      (ch_en),
  .ch_extclk  (ch_extclk),
  .ch_ovf_ie  (ch_ovf_ie),
  .ch_pulse   (ch_pulse)
);

// File: tb/tmrbank_front_bench.sv
`timescale 1ns/1ps
module tmrbank_front_bench;
  localparam int AW = 12;
  localparam int NC = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_req = 1'b0;
  logic            bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_rvalid;
  logic [NC-1:0]   ch_wr_stb;
  logic [1:0]      ch_wr_sel;
  logic [31:0]     ch_wr_data;
  logic [1:0]      ch_rd_sel;
  logic [32*NC-1:0] ch_rd_data;
  logic [NC-1:0]   ch_evt = '0;
  logic [NC-1:0]   ch_en, ch_extclk, ch_ovf_ie, ch_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // channel model: each returns a tag of its index and the selected word
  for (genvar i = 0; i < NC; i++) begin : g_model
    assign ch_rd_data[32*i +: 32] = 32'hC0DE_0000 | (32'(i) << 8) | 32'(ch_rd_sel);
  end

  tmrbank_front u_tmrbank_front (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ch_wr_stb(ch_wr_stb), .ch_wr_sel(ch_wr_sel),
    .ch_wr_data(ch_wr_data), .ch_rd_sel(ch_rd_sel), .ch_rd_data(ch_rd_data),
    .ch_evt(ch_evt), .ch_en(ch_en), .ch_extclk(ch_extclk),
    .ch_ovf_ie(ch_ovf_ie), .ch_pulse(ch_pulse)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    check("R12", 32'(bus_rvalid), 32'd1, "rvalid one cycle after read");
    bus_req = 1'b0;
  endtask

  // fields: we(1) addr(12) wdata(32) expected(32) requirement(4)
  localparam int NV = 26;
  localparam logic [80:0] VEC [NV] = '{
    {1'b1, 12'h030, 32'h12345678, 32'h0,        4'd3},  // R3 write control
    {1'b0, 12'h030, 32'h0,        32'h12345670, 4'd4},  // R4 low pulse bits dropped
    {1'b0, 12'h000, 32'h0,        32'hC0DE0000, 4'd1},  // R1 ch0 word0
    {1'b0, 12'h02C, 32'h0,        32'hC0DE0203, 4'd1},  // R1 ch2 word3
    {1'b0, 12'h044, 32'h0,        32'hC0DE0301, 4'd1},  // R1 ch3 past gap
    {1'b0, 12'h088, 32'h0,        32'hC0DE0702, 4'd1},  // R1 ch7 word2
    {1'b0, 12'h08C, 32'h0,        32'hC0DE0703, 4'd1},  // R1 ch7 word3
    {1'b0, 12'h090, 32'h0,        32'h0,        4'd10}, // R10 past last slot
    {1'b0, 12'h03C, 32'h0,        32'h0,        4'd10}, // R10 clear reads 0
    {1'b0, 12'h031, 32'h0,        32'h0,        4'd10}, // R10 unaligned
    {1'b1, 12'h090, 32'hFFFFFFFF, 32'h0,        4'd10}, // R10 write to hole
    {1'b1, 12'hFF0, 32'hFFFFFFFF, 32'h0,        4'd10}, // R10 write to hole
    {1'b0, 12'h030, 32'h0,        32'h12345670, 4'd10}, // R10 control intact
    {1'b0, 12'h038, 32'h0,        32'h0,        4'd7},  // R7 closed after reset
    {1'b1, 12'h03C, 32'hFFFFFFFF, 32'h0,        4'd8},  // R8 clear while closed
    {1'b0, 12'h030, 32'h0,        32'h12345670, 4'd8},  // R8 nothing cleared
    {1'b1, 12'h038, 32'h0000015C, 32'h0,        4'd7},  // R7 open code
    {1'b0, 12'h038, 32'h0,        32'h1,        4'd7},  // R7 reads open
    {1'b1, 12'h03C, 32'h0000FFFF, 32'h0,        4'd8},  // R8 clear low half
    {1'b0, 12'h030, 32'h0,        32'h12340000, 4'd8},  // R8 bits cleared
    {1'b1, 12'h038, 32'h00000002, 32'h0,        4'd7},  // R7 unknown code
    {1'b0, 12'h038, 32'h0,        32'h1,        4'd7},  // R7 still open
    {1'b1, 12'h038, 32'h000001D4, 32'h0,        4'd7},  // R7 close code
    {1'b0, 12'h038, 32'h0,        32'h0,        4'd7},  // R7 reads closed
    {1'b1, 12'h030, 32'h0,        32'h0,        4'd3},  // R3 zero control
    {1'b0, 12'h030, 32'h0,        32'h0,        4'd3}   // R3 reads zero
  };

  initial begin : watchdog
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R11 reset state at the ports
    check("R11", 32'(ch_en), 32'h0, "enables after reset");
    check("R11", 32'(ch_wr_stb), 32'h0, "strobes after reset");
    check("R11", 32'(bus_rvalid), 32'h0, "rvalid after reset");
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      logic        v_we;
      logic [11:0] v_a;
      logic [31:0] v_d, v_e;
      logic [3:0]  v_t;
      {v_we, v_a, v_d, v_e, v_t} = VEC[k];
      if (v_we) begin
        wr(v_a, v_d);
      end else begin
        rd(v_a, r);
        check($sformatf("R%0d", v_t), r, v_e, $sformatf("vector %0d", k));
      end
    end

    // R2 channel write strobes on both sides of the shared slot
    wr(12'h084, 32'hA5A5_0001);
    check("R2", 32'(ch_wr_stb), 32'h80, "strobe ch7");
    check("R2", 32'(ch_wr_sel), 32'h1, "word index ch7");
    check("R2", ch_wr_data, 32'hA5A5_0001, "write data ch7");
    @(negedge clk);
    check("R2", 32'(ch_wr_stb), 32'h0, "strobe lasts one cycle");
    wr(12'h018, 32'h0000_BEEF);
    check("R2", 32'(ch_wr_stb), 32'h02, "strobe ch1");
    check("R2", 32'(ch_wr_sel), 32'h2, "word index ch1");

    // R5 enable ch2 with config change: config first, enable a cycle later
    wr(12'h030, 32'h0000_0700);
    check("R5", 32'(ch_en[2]), 32'h0, "not yet running");
    @(negedge clk);
    check("R5", {30'b0, ch_ovf_ie[2], ch_extclk[2]}, 32'h3, "config landed");
    check("R5", 32'(ch_en[2]), 32'h0, "held while config lands");
    @(negedge clk);
    check("R5", 32'(ch_en[2]), 32'h1, "started after config");

    // R6 disable with config change: stop first
    wr(12'h030, 32'h0);
    @(negedge clk);
    check("R6", 32'(ch_en[2]), 32'h0, "stopped");
    check("R6", 32'(ch_extclk[2]), 32'h1, "config kept while stopping");
    @(negedge clk);
    check("R6", {30'b0, ch_ovf_ie[2], ch_extclk[2]}, 32'h0, "config cleared after stop");

    // R5 enable without config change starts right away
    wr(12'h030, 32'h0000_0600);
    repeat (2) @(negedge clk);
    wr(12'h030, 32'h0000_0700);
    @(negedge clk);
    check("R5", 32'(ch_en[2]), 32'h1, "fast start with settled config");

    // R4 pulse accepted only from channel 4 up
    wr(12'h030, 32'h0008_8888);
    repeat (2) @(negedge clk);
    check("R4", 32'(ch_pulse), 32'h10, "pulse outputs");
    rd(12'h030, r);
    check("R4", r, 32'h0008_0000, "pulse readback");

    // R9 event status
    @(negedge clk); ch_evt = 8'h21;
    @(negedge clk); ch_evt = 8'h00;
    rd(12'h034, r);
    check("R9", r, 32'h21, "events latched");
    wr(12'h034, 32'h1);
    rd(12'h034, r);
    check("R9", r, 32'h01, "write ANDs");
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h034; bus_wdata = 32'h0; ch_evt = 8'h40;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; ch_evt = 8'h00;
    rd(12'h034, r);
    check("R9", r, 32'h40, "event beats same-cycle clear");

    // R11 reset mid-run
    wr(12'h038, 32'h0000_015C);
    wr(12'h030, 32'h0000_0001);
    @(negedge clk); ch_evt = 8'h02;
    @(negedge clk); ch_evt = 8'h00; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R11", 32'(ch_en | ch_extclk | ch_ovf_ie | ch_pulse), 32'h0, "outputs after reset");
    rd(12'h030, r);
    check("R11", r, 32'h0, "control after reset");
    rd(12'h034, r);
    check("R11", r, 32'h0, "status after reset");
    rd(12'h038, r);
    check("R11", r, 32'h0, "lock after reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule